// File: doc/BRIEF.md
# Packet Receive Output Controller

This block is the sending side of a 32-bit packet receive bus that serves several ports over one shared data path. Each port has a receive FIFO in show-ahead form: while the FIFO is not empty, its head word is visible, and the block takes that word with a one-cycle pop strobe. A FIFO word holds 32 data bits, a first-word flag, a last-word flag, an error flag and a count of valid bytes. The link-layer device at the far end paces the block through an active-low enable, `renb_n`.

When the bus is free, the block picks the next port that has data, using round-robin order. It announces that port for one cycle with an address strobe that puts the port number on the data lines. It then streams that port's words until the packet ends or a programmable burst limit is reached. After that it returns to port selection. If the selected FIFO runs dry, the valid strobe drops and the transfer waits. If the link layer holds `renb_n` high, every output keeps its value and nothing is popped.

The controller has four states. `ST_IDLE` is port selection. `ST_ADDR` follows the cycle in which the address strobe was driven. `ST_DATA` follows a cycle in which a word was delivered. `ST_STALL` follows a cycle lost to an empty FIFO. All transitions occur only on an edge where `renb_n` is sampled low:
- IDLE→ADDR when some FIFO holds data.
- ADDR/DATA/STALL→STALL when the selected FIFO is empty.
- ADDR/DATA/STALL→IDLE after a last word, or after the word that reaches the burst limit.
- ADDR/DATA/STALL→DATA after any other delivered word.

Top module: `rx_out_ctrl`

## Requirements
- R1: While `rst_n` is low, all bus outputs (`rdat`, `rmod`, `rsop`, `reop`, `rerr`, `rval`, `rsx`) are zero.
- R2: When no transfer is active and some FIFO is non-empty, the next advancing cycle drives `rsx`=1 and `rval`=0, with the port number on `rdat[1:0]` and zeros above it. The port chosen is the first non-empty one counting upward, with wrap-around, from the port last announced; after reset the search starts at port 0. If every FIFO is empty, `rsx` and `rval` both stay low.
- R3: A word popped at a clock edge appears on `rdat`/`rsop`/`reop` with `rval`=1 in the cycle that follows. `rsop` is never high without `rval`.
- R4: On a last word, `rmod` equals 4 minus the 3-bit byte count, where count 4 gives 00 and count 1 gives 11. On every other word, `rmod` is 00.
- R5: `rerr` equals the word's error flag ANDed with its last-word flag, and only when `cfg_err_en`=1. Otherwise `rerr` stays low, and it is never high without `reop` and `rval`.
- R6: During a transfer, if the selected FIFO is empty at an advancing edge, no word is popped and `rval` is 0 in the next cycle. The transfer then resumes on the same port without a new `rsx`.
- R7: At an edge where `renb_n` is sampled high, no FIFO is popped and every bus output keeps its previous value.
- R8: After the word carrying `reop`, at least one advancing cycle with `rval`=0 follows (an `rsx` or idle cycle) before the next data word.
- R9: With `cfg_burst_max`=N≠0, at most N words are delivered after one `rsx`. After N words without `reop`, the block returns to port selection. N=0 means no limit.
- R10: At most one FIFO is popped per cycle. Each port's words leave the bus exactly once and in FIFO order, across any mix of pauses, underruns and port switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_err_en | input | 1 | Enables error reporting on `rerr` |
| cfg_burst_max | input | BW (6) | Word limit per announcement, 0 = no limit |
| fifo_empty | input | NP (4) | Per-port FIFO empty flags |
| fifo_data | input | NP*DW (128) | Per-port head data words |
| fifo_sop | input | NP | Per-port head first-word flags |
| fifo_eop | input | NP | Per-port head last-word flags |
| fifo_err | input | NP | Per-port head error flags |
| fifo_nbytes | input | NP*CW (12) | Per-port valid byte count, 1..4 |
| fifo_pop | output | NP | Per-port pop strobe, combinational |
| renb_n | input | 1 | Active-low enable from link layer |
| rdat | output | DW (32) | Data, or port number during `rsx` |
| rmod | output | MW (2) | Count of invalid trailing bytes on last word |
| rsop | output | 1 | First word of packet |
| reop | output | 1 | Last word of packet |
| rerr | output | 1 | Packet error, on last word only |
| rval | output | 1 | Data outputs valid |
| rsx | output | 1 | Port address cycle |

## Verification
`fifo_pop` is combinational and is due in the same cycle as the `renb_n` and empty flags it depends on. Every bus output is due exactly one cycle after the edge at which `renb_n` was sampled low. The bench sets its inputs at the falling edge and, 1 ns later, records the pop strobes, empty flags and enable for that cycle. At the next falling edge it judges the registered outputs against what that recorded cycle should have produced: a hold if the enable was high, otherwise an announcement, a word, a stall or idle.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_STALL = 2'd3
    } rxo_state_e;
endpackage

// File: rtl/rxo_rr_pick.sv
module rxo_rr_pick #(
    parameter int NP = 4,
    parameter int PW = 2
) (
    input  logic [NP-1:0] req,
    input  logic [PW-1:0] last,
    output logic          found,
    output logic [PW-1:0] pick
);
    int j;
    always_comb begin
        found = 1'b0;
        pick  = last;
        j     = 0;
        for (int i = 1; i <= NP; i++) begin
            j = (int'(last) + i) % NP;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = PW'(j);
            end
        end
    end
endmodule

// File: rtl/rxo_fmt.sv
module rxo_fmt #(
    parameter int DW = 32,
    parameter int MW = 2,
    parameter int CW = 3
) (
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          in_err,
    input  logic [CW-1:0] in_nbytes,
    input  logic          err_en,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    output logic          out_err,
    output logic [MW-1:0] out_mod
);
    localparam int BYTES = DW / 8;
    logic [CW-1:0] missing;

    always_comb begin
        missing  = CW'(BYTES) - in_nbytes;
        out_data = in_data;
        out_sop  = in_sop;
        out_eop  = in_eop;
        out_err  = in_err & in_eop & err_en;
        out_mod  = in_eop ? missing[MW-1:0] : '0;
    end
endmodule

// File: rtl/rx_out_ctrl.sv
module rx_out_ctrl
    import rxo_pkg::*;
#(
    parameter int NP = 4,
    parameter int DW = 32,
    parameter int BW = 6,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1,
    localparam int MW = $clog2(DW / 8),
    localparam int CW = MW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_err_en,
    input  logic [BW-1:0]    cfg_burst_max,
    input  logic [NP-1:0]    fifo_empty,
    input  logic [NP*DW-1:0] fifo_data,
    input  logic [NP-1:0]    fifo_sop,
    input  logic [NP-1:0]    fifo_eop,
    input  logic [NP-1:0]    fifo_err,
    input  logic [NP*CW-1:0] fifo_nbytes,
    output logic [NP-1:0]    fifo_pop,
    input  logic             renb_n,
    output logic [DW-1:0]    rdat,
    output logic [MW-1:0]    rmod,
    output logic             rsop,
    output logic             reop,
    output logic             rerr,
    output logic             rval,
    output logic             rsx
);
    rxo_state_e    st_q, st_d;
    logic [PW-1:0] cur_q, cur_d;
    logic [BW-1:0] cnt_q, cnt_d;
    logic          adv, sel_empty, take, burst_hit, found;
    logic [PW-1:0] pick;

    logic [DW-1:0] w_data, f_data;
    logic [CW-1:0] w_nb;
    logic          f_sop, f_eop, f_err;
    logic [MW-1:0] f_mod;

    assign adv       = !renb_n;
    assign sel_empty = fifo_empty[cur_q];
    assign take      = adv && (st_q != ST_IDLE) && !sel_empty;
    assign w_data    = fifo_data[cur_q*DW +: DW];
    assign w_nb      = fifo_nbytes[cur_q*CW +: CW];
    assign burst_hit = (cfg_burst_max != '0) &&
                       (({1'b0, cnt_q} + (BW+1)'(1)) == {1'b0, cfg_burst_max});

    rxo_rr_pick #(.NP(NP), .PW(PW)) u_pick (
        .req   (~fifo_empty),
        .last  (cur_q),
        .found (found),
        .pick  (pick)
    );

    rxo_fmt #(.DW(DW), .MW(MW), .CW(CW)) u_fmt (
        .in_data   (w_data),
        .in_sop    (fifo_sop[cur_q]),
        .in_eop    (fifo_eop[cur_q]),
        .in_err    (fifo_err[cur_q]),
        .in_nbytes (w_nb),
        .err_en    (cfg_err_en),
        .out_data  (f_data),
        .out_sop   (f_sop),
        .out_eop   (f_eop),
        .out_err   (f_err),
        .out_mod   (f_mod)
    );

    for (genvar g = 0; g < NP; g++) begin : g_pop
        assign fifo_pop[g] = take && (cur_q == PW'(g));
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (adv && found) begin
                    st_d  = ST_ADDR;
                    cur_d = pick;
                    cnt_d = '0;
                end
            end
            ST_ADDR, ST_DATA, ST_STALL: begin
                if (adv) begin
                    if (sel_empty) begin
                        st_d = ST_STALL;
                    end else begin
                        cnt_d = cnt_q + BW'(1);
                        if (f_eop || burst_hit) st_d = ST_IDLE;
                        else                    st_d = ST_DATA;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cur_q <= PW'(NP - 1);
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            cnt_q <= cnt_d;
        end
    end

    // registered bus outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdat <= '0; rmod <= '0; rsop <= 1'b0; reop <= 1'b0;
            rerr <= 1'b0; rval <= 1'b0; rsx <= 1'b0;
        end else if (adv) begin
            rdat <= '0; rmod <= '0; rsop <= 1'b0; reop <= 1'b0;
            rerr <= 1'b0; rval <= 1'b0; rsx <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (found) begin
                    rsx  <= 1'b1;
                    rdat <= {{(DW-PW){1'b0}}, pick};
                end
            end else if (take) begin
                rval <= 1'b1;
                rdat <= f_data;
                rsop <= f_sop;
                reop <= f_eop;
                rerr <= f_err;
                rmod <= f_mod;
            end
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_rsx_no_rval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsx |-> !rval);
    assert_pick_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && found) |-> !fifo_empty[pick]);
    assert_sop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsop |-> rval);
    assert_mod_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rmod != '0) |-> (reop && rval));
    assert_err_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rerr |-> (reop && rval));
    assert_err_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!cfg_err_en && !renb_n)) |-> !rerr);
    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_pop & fifo_empty) == '0));
    assert_hold_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(renb_n)) |-> $stable({rdat, rmod, rsop, reop, rerr, rval, rsx}));
    assert_no_pop_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        renb_n |-> (fifo_pop == '0));
    assert_pop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));
endmodule

// File: tb/rx_out_ctrl_tb.sv
module rx_out_ctrl_tb_top;
    localparam int NP = 4;
    localparam int DW = 32;
    localparam int BW = 6;
    localparam int CW = 3;
    localparam int NW = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_err_en = 1'b0;
    logic [BW-1:0] cfg_burst_max = '0;
    logic [NP-1:0] fifo_empty, fifo_sop, fifo_eop, fifo_err, fifo_pop;
    logic [NP*DW-1:0] fifo_data;
    logic [NP*CW-1:0] fifo_nbytes;
    logic renb_n = 1'b1;
    logic [DW-1:0] rdat;
    logic [1:0] rmod;
    logic rsop, reop, rerr, rval, rsx;

    always #5 clk = ~clk;

    rx_out_ctrl #(.NP(NP), .DW(DW), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_err_en(cfg_err_en), .cfg_burst_max(cfg_burst_max),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_sop(fifo_sop),
        .fifo_eop(fifo_eop), .fifo_err(fifo_err), .fifo_nbytes(fifo_nbytes),
        .fifo_pop(fifo_pop), .renb_n(renb_n), .rdat(rdat), .rmod(rmod),
        .rsop(rsop), .reop(reop), .rerr(rerr), .rval(rval), .rsx(rsx)
    );

    logic [31:0] e_data [NP][NW];
    bit          e_sop  [NP][NW];
    bit          e_eop  [NP][NW];
    bit          e_err  [NP][NW];
    logic [2:0]  e_nb   [NP][NW];
    int head [NP];
    int avail [NP];
    int rd_idx [NP];

    int total = 0;
    int bad = 0;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            fifo_empty[p] = (head[p] >= avail[p]);
            if (head[p] < NW) begin
                fifo_data[p*DW +: DW]   = e_data[p][head[p]];
                fifo_sop[p]             = e_sop[p][head[p]];
                fifo_eop[p]             = e_eop[p][head[p]];
                fifo_err[p]             = e_err[p][head[p]];
                fifo_nbytes[p*CW +: CW] = e_nb[p][head[p]];
            end else begin
                fifo_data[p*DW +: DW]   = '0;
                fifo_sop[p]             = 1'b0;
                fifo_eop[p]             = 1'b0;
                fifo_err[p]             = 1'b0;
                fifo_nbytes[p*CW +: CW] = 3'd4;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build();
        for (int p = 0; p < NP; p++) begin
            int pkt = 0;
            int left = 1 + (p % 5);
            for (int i = 0; i < NW; i++) begin
                bit first = (i == 0) || e_eop[p][(i > 0) ? i-1 : 0];
                if (first) left = 1 + ((p + pkt) % 5);
                e_sop[p][i]  = first;
                left--;
                e_eop[p][i]  = (left == 0) || (i == NW-1);
                if (e_eop[p][i]) pkt++;
                e_data[p][i] = 32'(p * 32'h01000193 + i * 32'h9E3779B1 + 7);
                e_err[p][i]  = ((i + p) % 3 == 0);
                e_nb[p][i]   = e_eop[p][i] ? 3'(1 + (i % 4)) : 3'd4;
            end
            head[p] = 0; avail[p] = 0; rd_idx[p] = 0;
        end
    endtask

    task automatic run_phase(input bit err_en, input int bmax, input int pause_pct, input int fill_pct);
        logic [NP-1:0] pop_k, emp_k;
        bit renb_k;
        logic [63:0] prev, cur_o;
        int last, cur, bcnt, cyc;
        bit in_xfer, done;
        build();
        cfg_err_en = err_en;
        cfg_burst_max = BW'(bmax);
        rst_n = 1'b0;
        renb_n = 1'b0;
        repeat (3) @(negedge clk);
        cur_o = {rdat, 26'd0, rmod, rsop, reop, rerr, rval, rsx};
        chk(cur_o == 64'd0, "R1 reset outputs", cur_o, 64'd0);
        rst_n = 1'b1;
        prev = 64'd0; last = NP-1; cur = 0; bcnt = 0; in_xfer = 0; cyc = 0;
        renb_n = ($urandom_range(99) < pause_pct);
        #1; pop_k = fifo_pop; emp_k = fifo_empty; renb_k = renb_n;
        done = 0;
        while (!done && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            cur_o = {rdat, 26'd0, rmod, rsop, reop, rerr, rval, rsx};
            if (renb_k) begin
                chk(cur_o == prev, "R7 hold while paused", cur_o, prev);
                chk(pop_k == '0, "R7 no pop while paused", pop_k, 0);
            end else begin
                chk($countones(pop_k) <= 1, "R10 single pop", pop_k, 0);
                if (rsx) begin
                    int port = int'(rdat[1:0]);
                    chk(!rval, "R2 rval low on rsx", rval, 0);
                    chk(!in_xfer, "R8 rsx only at boundary", in_xfer, 0);
                    chk(rdat[31:2] == 30'd0, "R2 upper address bits", rdat, port);
                    chk(!emp_k[port], "R2 chosen port has data", emp_k, port);
                    for (int j = 1; j < NP; j++) begin
                        int q = (last + j) % NP;
                        if (q == port) break;
                        chk(emp_k[q], "R2 round-robin order", port, q);
                    end
                    last = port; cur = port; bcnt = 0; in_xfer = 1;
                    chk(pop_k == '0, "R2 no pop on address cycle", pop_k, 0);
                end else if (rval) begin
                    int ix = rd_idx[cur];
                    chk(in_xfer, "R3 word inside transfer", in_xfer, 1);
                    chk(pop_k[cur], "R10 word matches pop", pop_k, 1 << cur);
                    if (ix < NW) begin
                        chk(rdat == e_data[cur][ix], "R3/R10 data order", rdat, e_data[cur][ix]);
                        chk(rsop == e_sop[cur][ix], "R3 rsop", rsop, e_sop[cur][ix]);
                        chk(reop == e_eop[cur][ix], "R3 reop", reop, e_eop[cur][ix]);
                        chk(rmod == (e_eop[cur][ix] ? 2'(4 - int'(e_nb[cur][ix])) : 2'd0),
                            "R4 rmod", rmod, e_eop[cur][ix] ? 4 - int'(e_nb[cur][ix]) : 0);
                        chk(rerr == (e_err[cur][ix] && e_eop[cur][ix] && err_en),
                            "R5 rerr", rerr, e_err[cur][ix] && e_eop[cur][ix] && err_en);
                        rd_idx[cur]++;
                        bcnt++;
                        if (bmax != 0) chk(bcnt <= bmax, "R9 burst limit", bcnt, bmax);
                        if (e_eop[cur][ix]) in_xfer = 0;
                        else if (bmax != 0 && bcnt == bmax) in_xfer = 0;
                    end else begin
                        chk(0, "R10 extra word", ix, NW);
                    end
                end else begin
                    if (in_xfer) begin
                        chk(emp_k[cur], "R6 stall only when empty", emp_k, 1 << cur);
                        chk(pop_k == '0, "R6 no pop on stall", pop_k, 0);
                    end else begin
                        chk(emp_k == '1, "R2 idle only when all empty", emp_k, 4'hF);
                    end
                end
            end
            prev = cur_o;
            for (int p = 0; p < NP; p++) begin
                if (pop_k[p]) head[p]++;
                if (avail[p] < NW && $urandom_range(99) < fill_pct) avail[p]++;
            end
            renb_n = ($urandom_range(99) < pause_pct);
            #1; pop_k = fifo_pop; emp_k = fifo_empty; renb_k = renb_n;
            done = 1;
            for (int p = 0; p < NP; p++) if (rd_idx[p] < NW) done = 0;
        end
        for (int p = 0; p < NP; p++)
            chk(rd_idx[p] == NW && head[p] == NW, "R10 all words delivered once", rd_idx[p], NW);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin head[p] = 0; avail[p] = 0; rd_idx[p] = 0; end
        run_phase(1'b1, 0, 0, 100);
        run_phase(1'b0, 3, 30, 40);
        run_phase(1'b1, 2, 20, 15);
        run_phase(1'b1, 5, 50, 70);
        run_phase(1'b0, 1, 10, 100);
        run_phase(1'b1, 0, 60, 5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule